// File: doc/BRIEF.md
# Four-Level Page Table Walker

The walker turns a 48-bit virtual address into a 52-bit physical address. It descends a fixed four-level radix tree of 8-byte entries held in memory. Software first loads the frame number of the top table into a root register. A requester then hands over a virtual address, together with two flags: whether the access is a write, and whether it comes from user mode.

For each level, the walker issues one read on a 64-bit memory port that uses a valid/ready request handshake. It checks the returned entry, and then either descends to the next level or stops. The walk ends in one of two ways:

- a physical address built from the last entry's frame number and the page offset, or
- a page fault, carrying a cause code and the level at which it was raised.

The walker serves one translation at a time. Its request-ready output stays low from the moment a request is accepted until the response pulse has ended.

Top module: `ptWalker`

## Requirements
- R1: After reset, reqReady is 1, memReqValid is 0 and rspValid is 0.
- R2: reqReady is 0 from the cycle after a request is accepted until the cycle after the response pulse. A request presented while reqReady is 0 is ignored and does not change the addresses the walk reads.
- R3: The read address for a level is {tableFrame, index, 3'b000}. The index is va[47:39] at level 4, va[38:30] at level 3, va[29:21] at level 2 and va[20:12] at level 1. At level 4, tableFrame is the root register, which is loaded from rootFrame when rootWe is 1.
- R4: For levels 3 to 1, tableFrame is bits 51:12 of the entry read at the level above.
- R5: memReqValid, once raised, stays high with a stable memAddr until memReqReady is 1. There is one read per level, and no new read is issued before the previous read's data has returned on memRdValid.
- R6: A walk with no fault makes exactly four reads. It returns rspFault=0, rspCause=0, rspLevel=0 and rspPaddr={bits 51:12 of the level-1 entry, va[11:0]}.
- R7: If entry bit 0 (present) is 0, the walk stops with rspFault=1 and cause 0. rspLevel gives the failing level, 4 to 1.
- R8: A write access that meets an entry with bit 1 (writable) equal to 0 faults with cause 1.
- R9: A user-mode access that meets an entry with bit 2 (user-allowed) equal to 0 faults with cause 2.
- R10: An entry with bit 7 (large page) set faults with cause 3, at any level.
- R11: Within one entry, the checks rank as not-present, then write-protect, then user-privilege, then large-page. The first level that fails ends the walk, and no further read is issued.
- R12: rspValid is a single-cycle pulse. When a fault is reported, rspPaddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootWe | input | 1 | Load the root register |
| rootFrame | input | 40 | Frame number of the top-level table |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept a request |
| reqVaddr | input | 48 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqUser | input | 1 | 1 = user mode, 0 = supervisor mode |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read request |
| memAddr | output | 52 | Byte address of the entry |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 64 | Entry returned by memory |
| rspValid | output | 1 | Result pulse |
| rspFault | output | 1 | 1 = page fault |
| rspCause | output | 2 | 0 not present, 1 write to read-only, 2 user to supervisor, 3 large page |
| rspLevel | output | 3 | Failing level 4..1, or 0 on success |
| rspPaddr | output | 52 | Translated physical address |

## Verification
Two things can meet in the same cycle. The first is a level's entry check deciding both whether to stop and which cause to report. The second is a new request arriving while a walk is still running. The bench sweeps the level at which a bad entry sits and the kind of bad entry, including entries that break two rules at once. It does this for all four combinations of write and user mode, so several checks fail together and the ranking of causes is exercised. In some walks the bench keeps a different request asserted during the busy cycles and confirms that every later read address still comes from the original request. Expected addresses, causes and levels are computed in the bench from the entry bits it supplies.

// File: rtl/ptwPkg.sv
`timescale 1ns/1ps
package ptwPkg;
  localparam int VA_W      = 48;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 9;
  localparam int LEVELS    = 4;
  localparam int FRAME_W   = 40;
  localparam int ENTRY_W   = 64;
  localparam int PA_W      = FRAME_W + OFF_W;
  localparam int LVL_W     = $clog2(LEVELS);
  localparam int LVLOUT_W  = $clog2(LEVELS + 1);
  localparam int ESHIFT_W  = OFF_W - IDX_W;
  localparam int FRAME_LSB = OFF_W;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_BIG     = 7;

  typedef enum logic [1:0] {
    CAUSE_ABSENT   = 2'd0,
    CAUSE_READONLY = 2'd1,
    CAUSE_PRIV     = 2'd2,
    CAUSE_BIGPAGE  = 2'd3
  } causeT;

  typedef struct packed {
    logic loadReq;
    logic stepDown;
    logic latchFault;
    logic latchDone;
  } strobeT;
endpackage

// File: rtl/ptwCtrl.sv
`timescale 1ns/1ps
module ptwCtrl import ptwPkg::*; (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   memReqReady,
  input  logic   memRdValid,
  input  logic   entryFault,
  input  logic   lastLevel,
  output logic   reqReady,
  output logic   memReqValid,
  output logic   rspValid,
  output strobeT strobe
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} stateT;
  stateT state, stateNext;
  logic [LVLOUT_W-1:0] readCnt;

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE);
  assign rspValid    = (state == S_RESP);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.loadReq = 1'b1;
        stateNext      = S_ISSUE;
      end
      S_ISSUE: if (memReqReady) stateNext = S_WAIT;
      S_WAIT: if (memRdValid) begin
        if (entryFault) begin
          strobe.latchFault = 1'b1;
          stateNext         = S_RESP;
        end else if (lastLevel) begin
          strobe.latchDone = 1'b1;
          stateNext        = S_RESP;
        end else begin
          strobe.stepDown = 1'b1;
          stateNext       = S_ISSUE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      readCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.loadReq) readCnt <= '0;
      else if (memReqValid && memReqReady) readCnt <= readCnt + 1'b1;
    end
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);
  assert_read_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (readCnt < LVLOUT_W'(LEVELS)));
  assert_full_walk_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchDone |-> (readCnt == LVLOUT_W'(LEVELS)));
  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

// File: rtl/ptwDatapath.sv
`timescale 1ns/1ps
module ptwDatapath import ptwPkg::*; (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic               rootWe,
  input  logic [FRAME_W-1:0] rootFrame,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic               reqWrite,
  input  logic               reqUser,
  input  logic [ENTRY_W-1:0] memRdData,
  output logic [PA_W-1:0]    memAddr,
  output logic               entryFault,
  output logic               lastLevel,
  output logic               rspFault,
  output logic [1:0]         rspCause,
  output logic [LVLOUT_W-1:0] rspLevel,
  output logic [PA_W-1:0]    rspPaddr
);
  logic [FRAME_W-1:0] rootReg, baseReg;
  logic [VA_W-1:0]    vaReg;
  logic               wrReg, usrReg;
  logic [LVL_W-1:0]   lvlReg;
  logic [IDX_W-1:0]   levelIdx [LEVELS];
  causeT              entryCause, causeReg;
  logic [FRAME_W-1:0] entryFrame;

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : gIdx
      assign levelIdx[g] = vaReg[OFF_W + IDX_W*g +: IDX_W];
    end
  endgenerate

  assign memAddr    = {baseReg, levelIdx[lvlReg], {ESHIFT_W{1'b0}}};
  assign lastLevel  = (lvlReg == '0);
  assign entryFrame = memRdData[FRAME_LSB +: FRAME_W];
  assign rspCause   = causeReg;

  always_comb begin
    entryFault = 1'b1;
    entryCause = CAUSE_ABSENT;
    if (!memRdData[BIT_PRESENT])                  entryCause = CAUSE_ABSENT;
    else if (wrReg && !memRdData[BIT_WRITE])      entryCause = CAUSE_READONLY;
    else if (usrReg && !memRdData[BIT_USER])      entryCause = CAUSE_PRIV;
    else if (memRdData[BIT_BIG])                  entryCause = CAUSE_BIGPAGE;
    else                                          entryFault = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootReg  <= '0;
      baseReg  <= '0;
      vaReg    <= '0;
      wrReg    <= 1'b0;
      usrReg   <= 1'b0;
      lvlReg   <= '0;
      rspFault <= 1'b0;
      causeReg <= CAUSE_ABSENT;
      rspLevel <= '0;
      rspPaddr <= '0;
    end else begin
      if (rootWe) rootReg <= rootFrame;
      if (strobe.loadReq) begin
        vaReg   <= reqVaddr;
        wrReg   <= reqWrite;
        usrReg  <= reqUser;
        baseReg <= rootReg;
        lvlReg  <= LVL_W'(LEVELS - 1);
      end
      if (strobe.stepDown) begin
        baseReg <= entryFrame;
        lvlReg  <= lvlReg - 1'b1;
      end
      if (strobe.latchFault) begin
        rspFault <= 1'b1;
        causeReg <= entryCause;
        rspLevel <= LVLOUT_W'(lvlReg) + 1'b1;
        rspPaddr <= '0;
      end
      if (strobe.latchDone) begin
        rspFault <= 1'b0;
        causeReg <= CAUSE_ABSENT;
        rspLevel <= '0;
        rspPaddr <= {entryFrame, vaReg[OFF_W-1:0]};
      end
    end
  end

  assert_stepdown_not_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepDown |-> !lastLevel);
  assert_fault_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchFault |=> (rspFault && rspLevel >= 1 && rspLevel <= LVLOUT_W'(LEVELS) && rspPaddr == '0));
  assert_done_clean_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchDone |=> (!rspFault && rspLevel == '0));
endmodule

// File: rtl/ptWalker.sv
`timescale 1ns/1ps
module ptWalker import ptwPkg::*; (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rootWe,
  input  logic [FRAME_W-1:0]  rootFrame,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic                reqWrite,
  input  logic                reqUser,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [PA_W-1:0]     memAddr,
  input  logic                memRdValid,
  input  logic [ENTRY_W-1:0]  memRdData,
  output logic                rspValid,
  output logic                rspFault,
  output logic [1:0]          rspCause,
  output logic [LVLOUT_W-1:0] rspLevel,
  output logic [PA_W-1:0]     rspPaddr
);
  strobeT strobe;
  logic   entryFault, lastLevel;

  ptwCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReqReady(memReqReady),
    .memRdValid(memRdValid), .entryFault(entryFault), .lastLevel(lastLevel),
    .reqReady(reqReady), .memReqValid(memReqValid), .rspValid(rspValid),
    .strobe(strobe)
  );

  ptwDatapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rootWe(rootWe), .rootFrame(rootFrame),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .reqUser(reqUser), .memRdData(memRdData),
    .memAddr(memAddr), .entryFault(entryFault), .lastLevel(lastLevel),
    .rspFault(rspFault), .rspCause(rspCause), .rspLevel(rspLevel), .rspPaddr(rspPaddr)
  );

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memAddr));
endmodule

// File: tb/ptWalker_test.sv
`timescale 1ns/1ps
module ptWalker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rootWe = 1'b0;
  logic [39:0] rootFrame = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [51:0] memAddr;
  logic        memRdValid = 1'b0;
  logic [63:0] memRdData = '0;
  logic        rspValid;
  logic        rspFault;
  logic [1:0]  rspCause;
  logic [2:0]  rspLevel;
  logic [51:0] rspPaddr;

  int nChecks = 0;
  int nFail = 0;
  logic [39:0] rootVal = '0;
  logic [63:0] entArr [4];

  always #4 clk = ~clk;

  ptWalker uut (
    .clk(clk), .rstN(rstN), .rootWe(rootWe), .rootFrame(rootFrame),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memAddr(memAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .rspValid(rspValid), .rspFault(rspFault),
    .rspCause(rspCause), .rspLevel(rspLevel), .rspPaddr(rspPaddr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic setRoot(input logic [39:0] v);
    @(negedge clk);
    rootWe = 1'b1; rootFrame = v;
    @(negedge clk);
    rootWe = 1'b0; rootFrame = ~v;
    rootVal = v;
  endtask

  task automatic runWalk(input logic [47:0] va, input logic wr, input logic usr,
                         input int dly, input bit poke);
    logic [39:0] base;
    logic        expFault;
    logic [1:0]  expCause;
    logic [2:0]  expLvl;
    logic [63:0] e;
    logic [51:0] expAddr;
    string       tag;
    base = rootVal; expFault = 1'b0; expCause = 2'd0; expLvl = 3'd0;
    @(negedge clk);
    chk("R2 idle ready", 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr; reqUser = usr;
    @(negedge clk);
    if (poke) begin
      reqVaddr = ~va; reqWrite = ~wr; reqUser = ~usr;
    end else reqValid = 1'b0;
    chk("R2 busy not ready", 64'(reqReady), 64'd0);
    for (int l = 3; l >= 0; l--) begin
      int waitCnt;
      waitCnt = 0;
      while (!memReqValid && waitCnt < 20) begin @(negedge clk); waitCnt++; end
      expAddr = {base, va[12 + 9*l +: 9], 3'b000};
      tag = (l == 3) ? "R3 level-4 address" : "R4 next-level address";
      chk("R5 read issued", 64'(memReqValid), 64'd1);
      chk(tag, 64'(memAddr), 64'(expAddr));
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk("R5 request held", 64'(memReqValid), 64'd1);
        chk("R5 address stable", 64'(memAddr), 64'(expAddr));
      end
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      chk("R5 no read before data", 64'(memReqValid), 64'd0);
      for (int d = 0; d < dly; d++) @(negedge clk);
      e = entArr[l];
      memRdValid = 1'b1; memRdData = e;
      @(negedge clk);
      memRdValid = 1'b0; memRdData = '0;
      reqValid = 1'b0;
      if (!e[0])            begin expFault = 1'b1; expCause = 2'd0; end
      else if (wr && !e[1]) begin expFault = 1'b1; expCause = 2'd1; end
      else if (usr && !e[2]) begin expFault = 1'b1; expCause = 2'd2; end
      else if (e[7])        begin expFault = 1'b1; expCause = 2'd3; end
      if (expFault) begin
        expLvl = 3'(l + 1);
        break;
      end
      base = e[51:12];
    end
    case (expCause)
      2'd0: tag = expFault ? "R7 not present" : "R6 success";
      2'd1: tag = "R8 write protect";
      2'd2: tag = "R9 user privilege";
      default: tag = "R10 large page";
    endcase
    chk("R12 response pulse", 64'(rspValid), 64'd1);
    chk({tag, " fault flag"}, 64'(rspFault), 64'(expFault));
    chk({tag, " R11 cause"}, 64'(rspCause), 64'(expCause));
    chk({tag, " R11 level"}, 64'(rspLevel), 64'(expLvl));
    chk({tag, " R12 paddr"}, 64'(rspPaddr), expFault ? 64'd0 : 64'({base, va[11:0]}));
    chk("R11 no read after result", 64'(memReqValid), 64'd0);
    @(negedge clk);
    chk("R12 pulse ends", 64'(rspValid), 64'd0);
    chk("R2 ready again", 64'(reqReady), 64'd1);
  endtask

  function automatic logic [11:0] kindFlags(input int kind);
    case (kind)
      1: return 12'h006;
      2: return 12'h005;
      3: return 12'h003;
      4: return 12'h087;
      5: return 12'h080;
      6: return 12'h001;
      default: return 12'h007;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 64'(reqReady), 64'd1);
    chk("R1 reset no read", 64'(memReqValid), 64'd0);
    chk("R1 reset no response", 64'(rspValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(reqReady), 64'd1);
    begin
      int t;
      t = 0;
      for (int fl = 0; fl < 4; fl++) begin
        for (int kind = 0; kind < 7; kind++) begin
          for (int wu = 0; wu < 4; wu++) begin
            logic [47:0] va;
            if (t % 16 == 0) setRoot({8'h3C, 16'(t * 13 + 7), 16'hBEEF});
            for (int l = 0; l < 4; l++) begin
              logic [39:0] fr;
              logic [11:0] fg;
              fr = {8'(8'h30 + l * 3), 16'(t * 7 + 1), 16'(16'h5A00 + l)};
              fg = (l == fl) ? kindFlags(kind) : 12'h007;
              entArr[l] = {12'hA5C, fr, fg};
            end
            va = {16'(t * 97 + 3), 16'(t * 131 + 5), 16'(t * 29 + 11)};
            runWalk(va, wu[0], wu[1], t % 3, (t % 5) == 0);
            t++;
          end
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule